// File: doc/BRIEF.md
# Cluster Issue-Width Controller

This block sets how many issue slots an 8-wide core keeps active. The core is split into two clusters of four slots. The controller adds up the number of instructions issued over each fixed-length sampling window. When a window closes, it compares the average issue rate with two thresholds. It then keeps the current width or moves one step between 8, 6 and 4 slots. At 6 slots the upper half of the second cluster is switched off. At 4 slots the whole second cluster is switched off.

The block produces two separate per-slot masks. One tells dispatch which slots it may use. The other drives the clock enables of the functional units behind each slot. A per-cluster clock enable is derived from the unit enables. When slots are removed, dispatch to them stops first, and their units keep running until in-flight work has drained. When slots are restored, the units are clocked again one cycle before dispatch may use them. The gating cells and the dispatch logic sit outside this block.

Top module: `issue_width_ctrl`

## Requirements
- R1: After reset, `width_o` reads 8 and every bit of `slot_en_o`, `fu_clk_en_o` and `clus_clk_en_o` is 1.
- R2: The total used for a decision is the sum of `issue_cnt_i` over every cycle of the window, including the cycle in which `win_end_i` is high. The running sum then restarts from zero.
- R3: With a window total T over W cycles, the width drops one step when T/W is below the next lower width minus 1. At 8 slots this means T/W < 5. At 6 slots it means T/W < 3. At 4 slots the width never drops.
- R4: The width rises one step when T/W is at least the current width minus 0.5. At 4 slots this means T/W >= 3.5. At 6 slots it means T/W >= 5.5. At 8 slots the width never rises.
- R5: The width changes by at most one step per window and otherwise holds.
- R6: In a settled state, slot k is enabled when k is below the width, with slots 0-3 in cluster 0 and slots 4-7 in cluster 1. Both masks then match. `clus_clk_en_o[c]` is the OR of the unit enables of cluster c. `width_o` is the slot count in binary.
- R7: On a drop decided at boundary edge E, the removed slots' `slot_en_o` bits clear at E. Their `fu_clk_en_o` bits clear two cycles later, and `width_o` takes the new value on that same edge.
- R8: On a rise decided at edge E, the added slots' `fu_clk_en_o` bits set at E. `slot_en_o` and `width_o` follow one cycle later.
- R9: The width changes only within the few cycles after a window boundary, never in the middle of a window.
- R10: A slot is never enabled for dispatch while its functional unit clock is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_end_i | input | 1 | High in the last cycle of each sampling window |
| issue_cnt_i | input | 4 | Instructions issued this cycle (0 to 8) |
| width_o | output | 4 | Current issue width (4, 6 or 8) |
| slot_en_o | output | 8 | Per-slot dispatch permission |
| fu_clk_en_o | output | 8 | Per-slot functional-unit clock enable |
| clus_clk_en_o | output | 2 | Per-cluster clock enable |

## Verification
The bench starts from each of the three widths and sweeps every possible window total. It runs each total twice, once with the issues packed at the start of the window and once packed at the end. A design that ignored the boundary cycle's count, or used `<=` where `<` is meant at the 5, 3, 3.5 and 5.5 thresholds, would pick the wrong width for totals such as 79/80, 47/48, 55/56 and 87/88. In the cycles right after every boundary, the bench checks both masks against the drain and wake orderings. Gating units before dispatch has stopped, or opening dispatch before the units are clocked, shows up as a mismatch in one of those cycles.

// File: rtl/iwc_pkg.sv
package iwc_pkg;

  typedef enum logic [1:0] {
    WID_NARROW = 2'd0,
    WID_MID    = 2'd1,
    WID_FULL   = 2'd2
  } wid_e;

  // number of live slots for a width code, s = slots per cluster
  function automatic int unsigned wid_slots(wid_e w, int unsigned s);
    case (w)
      WID_FULL: return 2 * s;
      WID_MID:  return s + s / 2;
      default:  return s;
    endcase
  endfunction

  function automatic wid_e step_down(wid_e w);
    case (w)
      WID_FULL: return WID_MID;
      default:  return WID_NARROW;
    endcase
  endfunction

  function automatic wid_e step_up(wid_e w);
    case (w)
      WID_NARROW: return WID_MID;
      default:    return WID_FULL;
    endcase
  endfunction

  // average < (lower width - 1)  <=>  total < (lower - 1) * win
  function automatic logic want_drop(wid_e w, int unsigned total,
                                     int unsigned s, int unsigned win);
    if (w == WID_NARROW) return 1'b0;
    return total < (wid_slots(step_down(w), s) - 1) * win;
  endfunction

  // average >= width - 0.5  <=>  2 * total >= (2 * width - 1) * win
  function automatic logic want_rise(wid_e w, int unsigned total,
                                     int unsigned s, int unsigned win);
    if (w == WID_FULL) return 1'b0;
    return 2 * total >= (2 * wid_slots(w, s) - 1) * win;
  endfunction

endpackage

// File: rtl/iwc_window_accum.sv
module iwc_window_accum #(
  parameter int CNT_W = 4,
  parameter int ACC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] issue_cnt_i,
  output logic [ACC_W-1:0] win_total_o
);

  logic [ACC_W-1:0] acc_q;

  // the boundary cycle's own count is part of the closing total
  assign win_total_o = acc_q + ACC_W'(issue_cnt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (win_end_i) acc_q <= '0;
    else                acc_q <= win_total_o;
  end

endmodule

// File: rtl/iwc_width_policy.sv
module iwc_width_policy
  import iwc_pkg::*;
#(
  parameter int S     = 4,
  parameter int WIN   = 1024,
  parameter int ACC_W = 14
) (
  input  wid_e             cur_i,
  input  logic [ACC_W-1:0] total_i,
  output logic             go_down_o,
  output logic             go_up_o,
  output wid_e             nxt_o
);

  always_comb begin
    go_down_o = want_drop(cur_i, 32'(total_i), S, WIN);
    go_up_o   = !go_down_o && want_rise(cur_i, 32'(total_i), S, WIN);
    if (go_down_o)    nxt_o = step_down(cur_i);
    else if (go_up_o) nxt_o = step_up(cur_i);
    else              nxt_o = cur_i;
  end

endmodule

// File: rtl/iwc_enable_seq.sv
module iwc_enable_seq
  import iwc_pkg::*;
#(
  parameter int S     = 4,
  parameter int DRAIN = 2,
  localparam int N    = 2 * S,
  localparam int DW   = $clog2(DRAIN + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         decide_i,
  input  logic         go_down_i,
  input  logic         go_up_i,
  input  wid_e         nxt_i,
  output wid_e         width_o,
  output logic [N-1:0] slot_en_o,
  output logic [N-1:0] fu_en_o,
  output logic         busy_o
);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_DRAIN, SEQ_WAKE} seq_e;

  seq_e            st_q;
  wid_e            cur_q, tgt_q;
  logic [DW-1:0]   cnt_q;
  logic [N-1:0]    slot_q, fu_q;

  function automatic logic [N-1:0] wid_mask(wid_e w);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i < int'(wid_slots(w, S)));
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cur_q  <= WID_FULL;
      tgt_q  <= WID_FULL;
      cnt_q  <= '0;
      slot_q <= '1;
      fu_q   <= '1;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (decide_i && go_down_i) begin
            slot_q <= wid_mask(nxt_i);        // stop dispatch first
            tgt_q  <= nxt_i;
            cnt_q  <= DW'(DRAIN - 1);
            st_q   <= SEQ_DRAIN;
          end else if (decide_i && go_up_i) begin
            fu_q   <= wid_mask(nxt_i);        // clocks back first
            tgt_q  <= nxt_i;
            st_q   <= SEQ_WAKE;
          end
        end
        SEQ_DRAIN: begin
          if (cnt_q == '0) begin
            fu_q  <= wid_mask(tgt_q);
            cur_q <= tgt_q;
            st_q  <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          slot_q <= wid_mask(tgt_q);
          cur_q  <= tgt_q;
          st_q   <= SEQ_IDLE;
        end
      endcase
    end
  end

  assign width_o   = cur_q;
  assign slot_en_o = slot_q;
  assign fu_en_o   = fu_q;
  assign busy_o    = (st_q != SEQ_IDLE);

endmodule

// File: rtl/issue_width_ctrl.sv
module issue_width_ctrl
  import iwc_pkg::*;
#(
  parameter int  SLOTS_PER_CLUSTER = 4,
  parameter int  WIN_CYCLES        = 1024,
  parameter int  DRAIN_CYCLES      = 2,
  localparam int N     = 2 * SLOTS_PER_CLUSTER,
  localparam int CNT_W = $clog2(N + 1),
  localparam int WW    = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] issue_cnt_i,
  output logic [WW-1:0]    width_o,
  output logic [N-1:0]     slot_en_o,
  output logic [N-1:0]     fu_clk_en_o,
  output logic [1:0]       clus_clk_en_o
);

  localparam int ACC_W = $clog2(N * WIN_CYCLES + 1);

  // named internal events, observed by the bound checker
  logic [ACC_W-1:0] win_total;
  logic             pol_down, pol_up;
  wid_e             pol_nxt, cur_wid;
  logic             seq_busy;

  iwc_window_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_end_i   (win_end_i),
    .issue_cnt_i (issue_cnt_i),
    .win_total_o (win_total)
  );

  iwc_width_policy #(.S(SLOTS_PER_CLUSTER), .WIN(WIN_CYCLES), .ACC_W(ACC_W)) u_policy (
    .cur_i     (cur_wid),
    .total_i   (win_total),
    .go_down_o (pol_down),
    .go_up_o   (pol_up),
    .nxt_o     (pol_nxt)
  );

  iwc_enable_seq #(.S(SLOTS_PER_CLUSTER), .DRAIN(DRAIN_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .decide_i  (win_end_i),
    .go_down_i (pol_down),
    .go_up_i   (pol_up),
    .nxt_i     (pol_nxt),
    .width_o   (cur_wid),
    .slot_en_o (slot_en_o),
    .fu_en_o   (fu_clk_en_o),
    .busy_o    (seq_busy)
  );

  assign width_o = WW'(wid_slots(cur_wid, SLOTS_PER_CLUSTER));

  for (genvar c = 0; c < 2; c++) begin : g_clus
    assign clus_clk_en_o[c] = |fu_clk_en_o[c*SLOTS_PER_CLUSTER +: SLOTS_PER_CLUSTER];
  end

endmodule

// File: rtl/issue_width_ctrl_chk.sv
module issue_width_ctrl_chk #(
  parameter int  S     = 4,
  parameter int  DRAIN = 2,
  localparam int N     = 2 * S,
  localparam int WW    = $clog2(N + 1),
  localparam int SW    = $clog2(DRAIN + 3)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_end,
  input logic [N-1:0]  slot_en,
  input logic [N-1:0]  fu_en,
  input logic [WW-1:0] width,
  input logic          busy
);

  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_q <= SW'(DRAIN + 2);
    else if (win_end)                     since_q <= '0;
    else if (since_q < SW'(DRAIN + 2))    since_q <= since_q + 1'b1;
  end

  function automatic logic [N-1:0] thermo(logic [WW-1:0] w);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i < int'(w));
    return m;
  endfunction

  assert_no_gated_dispatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en & ~fu_en) == '0);

  assert_settled_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fu_en == thermo(width)) && (slot_en == fu_en));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (width != $past(width)) |->
      (int'(width) + S/2 == int'($past(width))) || (int'($past(width)) + S/2 == int'(width)));

  assert_change_near_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (width != $past(width)) |-> (since_q <= SW'(DRAIN)));

  // a unit clock stops only after dispatch to it was off for two cycles
  assert_drain_before_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fu_en & $past(fu_en)) & ($past(slot_en) | $past(slot_en, 2))) == '0);

  // dispatch opens only on a slot whose unit was already clocked
  assert_clock_before_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en & ~$past(slot_en) & ~$past(fu_en)) == '0);

endmodule

bind issue_width_ctrl issue_width_ctrl_chk #(
  .S(SLOTS_PER_CLUSTER), .DRAIN(DRAIN_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .win_end (win_end_i),
  .slot_en (slot_en_o),
  .fu_en   (fu_clk_en_o),
  .width   (width_o),
  .busy    (seq_busy)
);

// File: tb/test_issue_width_ctrl.sv
module test_issue_width_ctrl;

  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_end = 1'b0;
  logic [3:0] issue_cnt = '0;
  logic [3:0] width;
  logic [7:0] slot_en, fu_en;
  logic [1:0] clus_en;

  int checks = 0;
  int errors = 0;
  int cur_m = 8;
  int nxt_m = 8;

  always #4 clk = ~clk;  // 125 MHz

  issue_width_ctrl #(
    .SLOTS_PER_CLUSTER(4), .WIN_CYCLES(WIN), .DRAIN_CYCLES(2)
  ) i_issue_width_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .win_end_i     (win_end),
    .issue_cnt_i   (issue_cnt),
    .width_o       (width),
    .slot_en_o     (slot_en),
    .fu_clk_en_o   (fu_en),
    .clus_clk_en_o (clus_en)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R3 / R4 / R5 restated with real-valued averages
  function automatic int next_width(int cur, int t);
    real avg = real'(t) / real'(WIN);
    if (cur == 8 && avg < 5.0) return 6;
    if (cur == 6 && avg < 3.0) return 4;
    if (cur == 4 && avg >= 3.5) return 6;
    if (cur == 6 && avg >= 5.5) return 8;
    return cur;
  endfunction

  function automatic int mask_of(int w);
    return (1 << w) - 1;
  endfunction

  // i: cycles since the previous boundary edge
  task automatic check_state(int i);
    int es, ef, ew;
    string tg;
    if (nxt_m < cur_m) begin
      tg = "R7 drain";
      es = mask_of(nxt_m);
      ef = (i <= 1) ? mask_of(cur_m) : mask_of(nxt_m);
      ew = (i <= 1) ? cur_m : nxt_m;
    end else if (nxt_m > cur_m) begin
      tg = "R8 wake";
      ef = mask_of(nxt_m);
      es = (i == 0) ? mask_of(cur_m) : mask_of(nxt_m);
      ew = (i == 0) ? cur_m : nxt_m;
    end else begin
      tg = "R6 hold";
      es = mask_of(cur_m);
      ef = es;
      ew = cur_m;
    end
    if (i == 8) tg = "R3_R4_R5_R9 settled";
    check({tg, " slot"}, int'(slot_en), es);
    check({tg, " fu"}, int'(fu_en), ef);
    check({tg, " width"}, int'(width), ew);
    check("R6 cluster", int'(clus_en), ((ef >> 4) != 0 ? 2 : 0) | ((ef & 15) != 0 ? 1 : 0));
    check("R10 no gated dispatch", int'(slot_en & ~fu_en), 0);
  endtask

  // one window with total t; back=1 packs the issues at the end (R2)
  task automatic run_window(int t, bit back);
    int rem = t;
    for (int i = 0; i < WIN; i++) begin
      int c;
      @(negedge clk);
      if (i <= 2 || i == 8) check_state(i);
      if (back) begin
        c = t - 8 * (WIN - 1 - i);
        if (c < 0) c = 0;
        if (c > 8) c = 8;
      end else begin
        c = (rem > 8) ? 8 : rem;
        rem -= c;
      end
      issue_cnt = 4'(c);
      win_end = (i == WIN - 1);
    end
    cur_m = nxt_m;
    nxt_m = next_width(cur_m, t);
  endtask

  task automatic goto_width(int w);
    run_window(0, 1'b0);
    run_window(0, 1'b0);
    if (w >= 6) run_window(8 * WIN, 1'b0);
    if (w == 8) run_window(8 * WIN, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 width", int'(width), 8);
    check("R1 slot", int'(slot_en), 255);
    check("R1 fu", int'(fu_en), 255);
    check("R1 cluster", int'(clus_en), 3);
    for (int s = 4; s <= 8; s += 2) begin
      for (int t = 0; t <= 8 * WIN; t++) begin
        for (int b = 0; b < 2; b++) begin
          goto_width(s);
          run_window(t, b[0]);  // R2 front/back packing
        end
      end
    end
    run_window(0, 1'b0);
    run_window(0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule